// File: doc/BRIEF.md
# FIFO-Fed Compatibility Parallel Transmitter

This block is the host side of a forward-only, byte-wide parallel printer port. Producer logic, typically a DMA channel, pushes bytes into a 16-entry FIFO through a simple write port. A small state machine then drains the FIFO onto the eight data lines. For each byte it drives the data, waits a programmable setup interval, pulls the active-low strobe low for a programmable width and releases it. After a programmable hold interval it returns to idle.

The engine paces itself only on the peripheral's Busy line, which passes through a two-flop synchronizer first. The acknowledge pulse from the peripheral goes unused. A new byte starts as soon as synchronized Busy is low and the FIFO holds data. Because the engine never waits for the acknowledge pulse, it can run close to the peak forward rate of the port, around 500 kilobytes per second at typical clock rates.

The engine has four states: `ST_IDLE`, `ST_SETUP`, `ST_STROBE` and `ST_HOLD`.

- `ST_IDLE` to `ST_SETUP`: taken when the FIFO is not empty and synchronized Busy is low. This transition pops one byte and latches it onto the data lines.
- `ST_SETUP` to `ST_STROBE`: taken once the setup count has run down.
- `ST_STROBE` to `ST_HOLD`: taken once the strobe count has run down.
- `ST_HOLD` to `ST_IDLE`: taken once the hold count has run down.

Each timed state lasts its programmed count plus one cycle. The three counts are read when their state is entered.

Top module: `pport_fifo_tx`

## Requirements
- R1: Bytes appear on `pd_out` in the order they were accepted by the FIFO. Each byte gets exactly one low pulse of `nstrobe_out`, and `pd_out` does not change while `nstrobe_out` is low.
- R2: A new byte appears on `pd_out` exactly `setup_len`+1 cycles before `nstrobe_out` falls.
- R3: `nstrobe_out` stays low for exactly `strobe_len`+1 cycles.
- R4: With data waiting and `busy_in` low, `nstrobe_out` falls again exactly `hold_len`+`setup_len`+3 cycles after it rose, so the byte period is `setup_len`+`strobe_len`+`hold_len`+4 cycles. `nstrobe_out` is high for at least two cycles between pulses.
- R5: No byte is started while synchronized Busy is high. Suppose the engine is idle with data waiting, and `busy_in` is first sampled low at clock edge 1. Then `nstrobe_out` is first low after edge `setup_len`+4; this delay consists of two synchronizer flops, the idle decision and the setup interval.
- R6: `nack_in` has no effect: the strobe timing, the byte order and the FIFO occupancy are the same whatever `nack_in` does.
- R7: While the FIFO is empty, `nstrobe_out` stays high and `pd_out` holds the last byte sent.
- R8: The FIFO holds 16 bytes. `fifo_count` reports the occupancy and `fifo_full` is high at 16 entries. A write while full is dropped and changes neither the count nor the byte stream.
- R9: After reset, `nstrobe_out` is 1, `pd_out` is 0x00, `fifo_empty` is 1, `fifo_full` is 0 and `fifo_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the FIFO |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_count | output | 5 | FIFO occupancy |
| setup_len | input | 8 | Setup interval minus one, in cycles |
| strobe_len | input | 8 | Strobe low width minus one, in cycles |
| hold_len | input | 8 | Hold interval minus one, in cycles |
| busy_in | input | 1 | Peripheral Busy, asynchronous |
| nack_in | input | 1 | Peripheral acknowledge, unused |
| pd_out | output | 8 | Parallel data lines |
| nstrobe_out | output | 1 | Active-low data strobe |

## Verification
Several kinds of internal fault show up at the ports within one byte period:

- A state machine stuck in a timed state, or a counter loaded with the wrong count, shifts the next `nstrobe_out` edge by at least one cycle.
- A synchronizer of the wrong depth moves the first strobe after Busy falls by a cycle.
- A FIFO pointer or count fault reorders the bytes or drops one, or lets the seventeenth write through. This is seen at the next strobe fall or on `fifo_count`.

The bench sweeps all 27 combinations of the values 0, 1 and 3 for the three counts. At each configuration it measures every edge interval exactly and checks every byte's value and position.

// File: rtl/pptx_pkg.sv
package pptx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } pptx_state_e;

endpackage

// File: rtl/pptx_fifo.sv
module pptx_fifo #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              full,
    output logic              empty,
    output logic [CNT_W-1:0]  count
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] wr_ptr_q;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic              push_ok;
    logic              pop_ok;

    assign push_ok = push && (count_q != CNT_W'(DEPTH));
    assign pop_ok  = pop && (count_q != '0);

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
            end
            if (pop_ok) begin
                rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_data = mem_q[rd_ptr_q];
    assign full      = (count_q == CNT_W'(DEPTH));
    assign empty     = (count_q == '0);
    assign count     = count_q;

endmodule

// File: rtl/pptx_sync.sv
module pptx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    generate
        if (STAGES <= 1) begin : g_single
            logic flop_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flop_q <= RESET_VAL;
                end else begin
                    flop_q <= async_i;
                end
            end
            assign sync_o = flop_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_i};
                end
            end
            assign sync_o = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pptx_engine.sv
module pptx_engine
    import pptx_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_head,
    input  logic              busy_s,
    input  logic [CFG_W-1:0]  setup_len,
    input  logic [CFG_W-1:0]  strobe_len,
    input  logic [CFG_W-1:0]  hold_len,
    output logic              pop_o,
    output logic [DATA_W-1:0] pd_o,
    output logic              nstrobe_o
);

    pptx_state_e       state_q;
    pptx_state_e       state_d;
    logic [CFG_W-1:0]  cnt_q;
    logic [CFG_W-1:0]  cnt_d;
    logic [DATA_W-1:0] data_q;
    logic              launch;
    logic              cnt_done;

    assign cnt_done = (cnt_q == '0);

    // next-state and interval counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!fifo_empty && !busy_s) begin
                    launch  = 1'b1;
                    state_d = ST_SETUP;
                    cnt_d   = setup_len;
                end
            end
            ST_SETUP: begin
                if (cnt_done) begin
                    state_d = ST_STROBE;
                    cnt_d   = strobe_len;
                end else begin
                    cnt_d = cnt_q - CFG_W'(1);
                end
            end
            ST_STROBE: begin
                if (cnt_done) begin
                    state_d = ST_HOLD;
                    cnt_d   = hold_len;
                end else begin
                    cnt_d = cnt_q - CFG_W'(1);
                end
            end
            ST_HOLD: begin
                if (cnt_done) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - CFG_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (launch) begin
                data_q <= fifo_head;
            end
        end
    end

    // outputs
    always_comb begin
        pop_o     = launch;
        pd_o      = data_q;
        nstrobe_o = (state_q != ST_STROBE);
    end

endmodule

// File: rtl/pport_fifo_tx.sv
module pport_fifo_tx #(
    parameter int DEPTH       = 16,
    parameter int CFG_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic [CNT_W-1:0] fifo_count,
    input  logic [CFG_W-1:0] setup_len,
    input  logic [CFG_W-1:0] strobe_len,
    input  logic [CFG_W-1:0] hold_len,
    input  logic             busy_in,
    input  logic             nack_in,
    output logic [7:0]       pd_out,
    output logic             nstrobe_out
);

    logic       pop_w;
    logic [7:0] head_w;
    logic       busy_sync_w;
    logic       empty_w;
    logic       unused_nack;

    // the acknowledge line takes no part in pacing
    assign unused_nack = nack_in;

    pptx_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (8),
        .CNT_W  (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop_w),
        .head_data (head_w),
        .full      (fifo_full),
        .empty     (empty_w),
        .count     (fifo_count)
    );

    pptx_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_busy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (busy_in),
        .sync_o  (busy_sync_w)
    );

    pptx_engine #(
        .CFG_W  (CFG_W),
        .DATA_W (8)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (empty_w),
        .fifo_head  (head_w),
        .busy_s     (busy_sync_w),
        .setup_len  (setup_len),
        .strobe_len (strobe_len),
        .hold_len   (hold_len),
        .pop_o      (pop_w),
        .pd_o       (pd_out),
        .nstrobe_o  (nstrobe_out)
    );

    assign fifo_empty = empty_w;

endmodule

// File: rtl/pptx_checker.sv
module pptx_checker #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             fifo_full,
    input logic             fifo_empty,
    input logic [CNT_W-1:0] fifo_count,
    input logic             pop,
    input logic             busy_s,
    input logic [7:0]       pd_out,
    input logic             nstrobe_out
);

    // R1: data lines steady while the strobe is low
    assert_data_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !nstrobe_out |-> $stable(pd_out));

    // R4: a released strobe stays high at least one more cycle
    assert_strobe_recovery_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nstrobe_out) |=> nstrobe_out);

    // R5: a byte is taken only when Busy is low and data is present
    assert_no_start_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (!busy_s && !fifo_empty));

    // R8: a write into a full FIFO without a pop leaves the count alone
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && !pop) |=> (fifo_count == $past(fifo_count)));

    // R8: occupancy never exceeds the depth
    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

endmodule

bind pport_fifo_tx pptx_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_pptx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .fifo_count  (fifo_count),
    .pop         (pop_w),
    .busy_s      (busy_sync_w),
    .pd_out      (pd_out),
    .nstrobe_out (nstrobe_out)
);

// File: tb/pport_fifo_tx_test.sv
`timescale 1ns/1ps
module pport_fifo_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       fifo_full;
    logic       fifo_empty;
    logic [4:0] fifo_count;
    logic [7:0] setup_len = 8'd0;
    logic [7:0] strobe_len = 8'd0;
    logic [7:0] hold_len = 8'd0;
    logic       busy_in = 1'b1;
    logic       nack_in = 1'b1;
    logic [7:0] pd_out;
    logic       nstrobe_out;

    always #2 clk = ~clk;

    pport_fifo_tx uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .fifo_full   (fifo_full),
        .fifo_empty  (fifo_empty),
        .fifo_count  (fifo_count),
        .setup_len   (setup_len),
        .strobe_len  (strobe_len),
        .hold_len    (hold_len),
        .busy_in     (busy_in),
        .nack_in     (nack_in),
        .pd_out      (pd_out),
        .nstrobe_out (nstrobe_out)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int cs = 0, cw = 0, ch = 0;
    logic [7:0] exp_q [0:1023];
    int tail = 0;
    int sent = 0;
    int gen = 0;
    int cyc = 0;
    int t_data = 0, t_fall = 0, t_rise = 0, c0 = 0;
    bit mon_on = 1'b0;
    bit first_in_burst = 1'b1;
    bit r5_armed = 1'b0;
    bit noise_on = 1'b0;
    logic prev_ns = 1'b1;
    logic [7:0] prev_pd = 8'h00;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // pseudo-random acknowledge activity, R6
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (noise_on) nack_in = lfsr[0];
    end

    // edge-interval monitor
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (pd_out !== prev_pd) t_data = cyc;
            if (prev_ns && !nstrobe_out) begin
                chk(pd_out == exp_q[sent], "R1 byte order", pd_out, exp_q[sent]);
                chk(cyc - t_data == cs + 1, "R2 setup interval", cyc - t_data, cs + 1);
                if (r5_armed) begin
                    chk(cyc - c0 == cs + 4, "R5 busy release to strobe", cyc - c0, cs + 4);
                    r5_armed = 1'b0;
                end else if (!first_in_burst) begin
                    chk(cyc - t_rise == ch + cs + 3, "R4 strobe gap", cyc - t_rise, ch + cs + 3);
                end
                first_in_burst = 1'b0;
                t_fall = cyc;
                sent++;
            end
            if (!prev_ns && nstrobe_out) begin
                chk(cyc - t_fall == cw + 1, "R3 strobe width", cyc - t_fall, cw + 1);
                t_rise = cyc;
            end
        end
        prev_ns = nstrobe_out;
        prev_pd = pd_out;
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            report();
        end
    end

    task automatic push_byte(input bit accept);
        logic [7:0] b;
        b = 8'(gen * 37 + 11);
        gen++;
        @(negedge clk); #1;
        wr_en = 1'b1;
        wr_data = b;
        if (accept) begin
            exp_q[tail] = b;
            tail++;
        end
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int s, input int w, input int h);
        cs = s; cw = w; ch = h;
        setup_len = 8'(s);
        strobe_len = 8'(w);
        hold_len = 8'(h);
    endtask

    task automatic release_busy();
        @(negedge clk); #1;
        busy_in = 1'b0;
        c0 = cyc;
        r5_armed = 1'b1;
        first_in_burst = 1'b1;
    endtask

    task automatic wait_drain();
        while (sent < tail) @(negedge clk);
        repeat (cw + ch + 8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(nstrobe_out == 1'b1, "R9 reset strobe", nstrobe_out, 1);
        chk(pd_out == 8'h00, "R9 reset data", pd_out, 0);
        chk(fifo_empty && !fifo_full, "R9 reset flags", {fifo_full, fifo_empty}, 1);
        chk(fifo_count == 5'd0, "R9 reset count", fifo_count, 0);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        mon_on = 1'b1;
        noise_on = 1'b1;

        // sweep of all count combinations, R1-R5 with acknowledge noise (R6)
        for (int s = 0; s < 3; s++) begin
            for (int w = 0; w < 3; w++) begin
                for (int h = 0; h < 3; h++) begin
                    busy_in = 1'b1;
                    repeat (6) @(negedge clk);
                    set_cfg((s == 2) ? 3 : s, (w == 2) ? 3 : w, (h == 2) ? 3 : h);
                    for (int k = 0; k < 4; k++) push_byte(1'b1);
                    release_busy();
                    wait_drain();
                end
            end
        end

        // R5: peripheral holds Busy for a while after every strobe
        busy_in = 1'b1;
        repeat (6) @(negedge clk);
        set_cfg(2, 1, 0);
        for (int k = 0; k < 4; k++) push_byte(1'b1);
        release_busy();
        for (int k = 0; k < 4; k++) begin
            while (nstrobe_out) @(negedge clk);
            #1 busy_in = 1'b1;
            while (!nstrobe_out) @(negedge clk);
            repeat (5) @(negedge clk);
            if (k < 3) begin
                #1;
                busy_in = 1'b0;
                c0 = cyc;
                r5_armed = 1'b1;
            end
        end
        repeat (8) @(negedge clk);
        chk(sent == tail, "R5 paced byte count", sent, tail);

        // R8: fill to depth, then one dropped write
        set_cfg(0, 0, 0);
        for (int k = 0; k < 16; k++) push_byte(1'b1);
        chk(fifo_full == 1'b1, "R8 full flag at 16", fifo_full, 1);
        chk(fifo_count == 5'd16, "R8 count at 16", fifo_count, 16);
        push_byte(1'b0);
        chk(fifo_count == 5'd16, "R8 count after dropped write", fifo_count, 16);

        // R6: acknowledge activity alone starts nothing
        begin
            int lows = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (!nstrobe_out) lows++;
            end
            chk(lows == 0, "R6 no strobe from acknowledge", lows, 0);
            chk(fifo_count == 5'd16, "R6 occupancy unchanged", fifo_count, 16);
        end

        release_busy();
        wait_drain();
        chk(sent == tail, "R8 sixteen bytes sent", sent, tail);
        chk(fifo_empty && fifo_count == 5'd0, "R8 drained", fifo_count, 0);

        // R7: empty FIFO with Busy low
        begin
            int lows = 0;
            int moved = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (!nstrobe_out) lows++;
                if (pd_out != exp_q[tail-1]) moved++;
            end
            chk(lows == 0, "R7 strobe idle when empty", lows, 0);
            chk(moved == 0, "R7 data holds last byte", pd_out, exp_q[tail-1]);
        end

        report();
    end

endmodule